// File: doc/BRIEF.md
# Keyboard Serial Frame Receiver

This block takes the two open-collector lines of a PC/AT-style keyboard, where the keyboard drives both the clock and the data, and turns each serial frame into a byte for the host. Both lines are first brought into the system clock domain through a flop chain. A falling edge is then found on the resynchronised clock line, and the data line is sampled on that edge. A frame has eleven bits: a low start bit, eight data bits with the least significant bit first, an odd parity bit and a stop bit. When a frame completes, the byte is placed in a one-entry output buffer and a full flag is raised. That flag can drive a host interrupt.

The receiver reports two errors. One flags a parity mismatch. The other flags a receive timeout, raised when the keyboard stops clocking part way through a frame. While the buffer holds an unread byte, or while host logic has withdrawn the receive enable, the block asks the line driver to hold the keyboard clock low. This keeps further frames from arriving.

The control is a four-state machine:
- `RX_IDLE`: waiting for a frame. Start edge: a falling clock edge with data low, while reception is enabled and the buffer is empty, moves it to `RX_DATA`. False start: an edge with data high leaves it in `RX_IDLE`.
- `RX_DATA`: shifts in the eight data bits. Data done: the eighth data edge moves it to `RX_PARITY`.
- `RX_PARITY`: Parity edge: captures the parity bit and moves to `RX_STOP`.
- `RX_STOP`: Stop edge: delivers the byte and returns to `RX_IDLE`.

Two abort transitions apply in any of the three busy states: gap timeout and enable drop. Either one returns the machine to `RX_IDLE` and discards the partial frame.

Top module: `kbd_frame_rx`

## Requirements
- R1: After reset: `rx_byte` is 0x00; `obf`, `irq`, `parity_err`, `timeout_err` and `rx_valid` are 0; `kb_clk_hold` is 0 when `rx_enable` is 1.
- R2: The eight data bits after the start bit are assembled least significant bit first into `rx_byte`.
- R3: On each delivered frame, `parity_err` becomes 1 if the eight data bits plus the parity bit hold an even number of ones. Otherwise it becomes 0.
- R4: Each completed frame gives exactly one single-cycle `rx_valid` pulse and sets `obf`.
- R5: `irq` is 1 exactly when `obf` is 1 and `irq_enable` is 1.
- R6: A `host_read` pulse clears `obf`.
- R7: `kb_clk_hold` is 1 while `obf` is 1 or `rx_enable` is 0. Edges arriving while `obf` is 1 start no frame, and `rx_byte` keeps its value.
- R8: If no falling clock edge arrives within TIMEOUT_CYCLES system clocks while a frame is in progress, the partial frame is dropped, `timeout_err` becomes 1, and neither `obf` nor `rx_valid` is raised.
- R9: A start edge that samples data high is a false start. The machine stays idle, no error flag changes, and a following valid frame is received normally.
- R10: Lowering `rx_enable` in the middle of a frame discards it. No byte is delivered and no error flag is set.
- R11: A completed frame clears `timeout_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kb_clk_in | input | 1 | Keyboard clock line as received |
| kb_dat_in | input | 1 | Keyboard data line as received |
| rx_enable | input | 1 | 1 allows reception; 0 inhibits it |
| irq_enable | input | 1 | 1 lets a full buffer raise `irq` |
| host_read | input | 1 | One-cycle pulse: host has taken the byte |
| rx_byte | output | 8 | Last delivered byte |
| rx_valid | output | 1 | One-cycle pulse when a byte is delivered |
| obf | output | 1 | Output buffer full |
| irq | output | 1 | Interrupt request |
| parity_err | output | 1 | Parity error on the last delivered frame |
| timeout_err | output | 1 | Last frame attempt ended in a clock gap timeout |
| kb_clk_hold | output | 1 | 1 asks the line driver to pull the keyboard clock low |

## Verification
The assertions assume that each low and high phase of the keyboard clock lasts well beyond the synchroniser depth. They also assume that the data line is stable around every falling edge and that `host_read` is a single-cycle pulse. The stimulus keeps to this by giving each bit 40 system clocks: data changes 10 cycles before the clock falls, the clock stays low for 20 cycles, and `host_read` is driven high for exactly one cycle. The bench shortens the timeout to 400 cycles so that a stalled frame can be reached within the run.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
    localparam int KB_DATA_BITS = 8;

    typedef enum logic [1:0] {
        RX_IDLE   = 2'd0,
        RX_DATA   = 2'd1,
        RX_PARITY = 2'd2,
        RX_STOP   = 2'd3
    } rx_state_t;
endpackage

// File: rtl/kbd_line_sync.sv
module kbd_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_sync
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= 1'b1;
                else        chain <= line_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[LAST-1:0], line_in};
            end
        end
    endgenerate

    assign line_sync = chain[LAST];
endmodule

// File: rtl/kbd_fall_detect.sv
module kbd_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic fall
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b1;
        else        level_q <= level;
    end

    assign fall = level_q & ~level;
endmodule

// File: rtl/kbd_gap_timer.sv
module kbd_gap_timer #(
    parameter int LIMIT = 24000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (!run || restart) cnt <= '0;
        else if (cnt != LAST)    cnt <= cnt + 1'b1;
    end

    assign expired = run && !restart && (cnt == LAST);
endmodule

// File: rtl/kbd_rx_fsm.sv
module kbd_rx_fsm
    import kbd_rx_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fall,
    input  logic                    din,
    input  logic                    enable,
    input  logic                    expired,
    input  logic                    host_read,
    output logic                    busy,
    output logic [KB_DATA_BITS-1:0] rx_byte,
    output logic                    rx_valid,
    output logic                    obf,
    output logic                    parity_err,
    output logic                    timeout_err
);
    localparam int CNT_W = $clog2(KB_DATA_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(KB_DATA_BITS - 1);

    rx_state_t state, state_nx;
    logic [KB_DATA_BITS-1:0] shreg;
    logic [CNT_W-1:0]        bit_cnt;
    logic                    par_bit;
    logic                    step;
    logic                    abort;

    assign step  = fall && enable && !expired;
    assign abort = !enable || expired;
    assign busy  = (state != RX_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE: begin
                if (fall && enable && !obf && !din) state_nx = RX_DATA;
            end
            RX_DATA: begin
                if (abort)                            state_nx = RX_IDLE;
                else if (fall && bit_cnt == LAST_BIT) state_nx = RX_PARITY;
            end
            RX_PARITY: begin
                if (abort)     state_nx = RX_IDLE;
                else if (fall) state_nx = RX_STOP;
            end
            RX_STOP: begin
                if (abort || fall) state_nx = RX_IDLE;
            end
            default: state_nx = RX_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg       <= '0;
            bit_cnt     <= '0;
            par_bit     <= 1'b0;
            rx_byte     <= '0;
            rx_valid    <= 1'b0;
            obf         <= 1'b0;
            parity_err  <= 1'b0;
            timeout_err <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (host_read) obf <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    bit_cnt <= '0;
                end
                RX_DATA: begin
                    if (step) begin
                        shreg   <= {din, shreg[KB_DATA_BITS-1:1]};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                RX_PARITY: begin
                    if (step) par_bit <= din;
                end
                RX_STOP: begin
                    if (step) begin
                        rx_byte     <= shreg;
                        rx_valid    <= 1'b1;
                        obf         <= 1'b1;
                        parity_err  <= ~(^{shreg, par_bit});
                        timeout_err <= 1'b0;
                    end
                end
                default: ;
            endcase
            if (state != RX_IDLE && enable && expired) timeout_err <= 1'b1;
        end
    end
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx #(
    parameter int TIMEOUT_CYCLES = 24000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kb_clk_in,
    input  logic       kb_dat_in,
    input  logic       rx_enable,
    input  logic       irq_enable,
    input  logic       host_read,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       obf,
    output logic       irq,
    output logic       parity_err,
    output logic       timeout_err,
    output logic       kb_clk_hold
);
    logic clk_s, dat_s, fall, busy, expired;

    kbd_line_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .line_in(kb_clk_in), .line_sync(clk_s));

    kbd_line_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .line_in(kb_dat_in), .line_sync(dat_s));

    kbd_fall_detect u_fall (
        .clk(clk), .rst_n(rst_n), .level(clk_s), .fall(fall));

    kbd_gap_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(busy), .restart(fall), .expired(expired));

    kbd_rx_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .fall(fall), .din(dat_s), .enable(rx_enable),
        .expired(expired), .host_read(host_read), .busy(busy),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .obf(obf),
        .parity_err(parity_err), .timeout_err(timeout_err));

    assign irq         = obf & irq_enable;
    assign kb_clk_hold = obf | ~rx_enable;
endmodule

// File: rtl/kbd_frame_rx_chk.sv
module kbd_frame_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_enable,
    input logic [7:0] rx_byte,
    input logic       rx_valid,
    input logic       obf,
    input logic       irq,
    input logic       timeout_err,
    input logic       kb_clk_hold
);
    p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_valid_sets_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> obf);

    p_no_irq_when_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !obf |-> !irq);

    p_hold_when_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        obf |-> kb_clk_hold);

    p_no_delivery_while_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        obf |=> !rx_valid);

    p_byte_only_on_delivery_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_byte));

    p_timeout_no_delivery_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> !rx_valid);

    p_delivery_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(rx_enable));
endmodule

bind kbd_frame_rx kbd_frame_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .obf(obf), .irq(irq), .timeout_err(timeout_err),
    .kb_clk_hold(kb_clk_hold));

// File: tb/kbd_frame_rx_test.sv
module kbd_frame_rx_test;
    localparam int TMO = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kb_clk_in = 1'b1, kb_dat_in = 1'b1;
    logic rx_enable = 1'b1, irq_enable = 1'b0, host_read = 1'b0;
    logic [7:0] rx_byte;
    logic rx_valid, obf, irq, parity_err, timeout_err, kb_clk_hold;

    int tests = 0, fails = 0, vcount = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    kbd_frame_rx #(.TIMEOUT_CYCLES(TMO), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .kb_clk_in(kb_clk_in), .kb_dat_in(kb_dat_in),
        .rx_enable(rx_enable), .irq_enable(irq_enable), .host_read(host_read),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .obf(obf), .irq(irq),
        .parity_err(parity_err), .timeout_err(timeout_err), .kb_clk_hold(kb_clk_hold));

    always @(posedge clk) if (rx_valid) vcount <= vcount + 1;

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        kb_dat_in = b;
        wait_cyc(10);
        kb_clk_in = 1'b0;
        wait_cyc(20);
        kb_clk_in = 1'b1;
        wait_cyc(10);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic good_par);
        logic par;
        par = good_par ? ~^d : ^d;
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        send_bit(par);
        send_bit(1'b1);
        wait_cyc(10);
    endtask

    task automatic do_read();
        host_read = 1'b1;
        wait_cyc(1);
        host_read = 1'b0;
        wait_cyc(2);
    endtask

    task automatic t_reset();
        chk("R1 rx_byte", rx_byte, 8'h00);
        chk("R1 obf", obf, 0);
        chk("R1 irq", irq, 0);
        chk("R1 parity_err", parity_err, 0);
        chk("R1 timeout_err", timeout_err, 0);
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 hold", kb_clk_hold, 0);
    endtask

    task automatic t_basic();
        int v0 = vcount;
        send_frame(8'hA5, 1'b1);
        chk("R2 byte A5", rx_byte, 8'hA5);
        chk("R4 one pulse", vcount - v0, 1);
        chk("R4 obf set", obf, 1);
        chk("R3 good parity", parity_err, 0);
        do_read();
        chk("R6 obf cleared", obf, 0);
        send_frame(8'h01, 1'b1);
        chk("R2 byte 01 lsb first", rx_byte, 8'h01);
        do_read();
    endtask

    task automatic t_parity();
        send_frame(8'h3C, 1'b0);
        chk("R3 bad parity flagged", parity_err, 1);
        chk("R3 byte still delivered", rx_byte, 8'h3C);
        do_read();
        send_frame(8'h80, 1'b1);
        chk("R3 flag cleared by good frame", parity_err, 0);
        chk("R2 byte 80", rx_byte, 8'h80);
        do_read();
    endtask

    task automatic t_irq();
        send_frame(8'h11, 1'b1);
        irq_enable = 1'b1;
        wait_cyc(1);
        chk("R5 irq full enabled", irq, 1);
        irq_enable = 1'b0;
        wait_cyc(1);
        chk("R5 irq disabled", irq, 0);
        irq_enable = 1'b1;
        do_read();
        chk("R5 irq empty", irq, 0);
        irq_enable = 1'b0;
    endtask

    task automatic t_inhibit_full();
        int v0;
        send_frame(8'h11, 1'b1);
        v0 = vcount;
        chk("R7 hold while full", kb_clk_hold, 1);
        send_frame(8'h22, 1'b1);
        chk("R7 byte kept while full", rx_byte, 8'h11);
        chk("R7 no delivery while full", vcount - v0, 0);
        do_read();
        chk("R7 hold released", kb_clk_hold, 0);
        send_frame(8'h22, 1'b1);
        chk("R7 next frame taken", rx_byte, 8'h22);
        do_read();
    endtask

    task automatic t_disable();
        int v0 = vcount;
        rx_enable = 1'b0;
        wait_cyc(1);
        chk("R7 hold when disabled", kb_clk_hold, 1);
        send_frame(8'h66, 1'b1);
        chk("R7 no delivery when disabled", vcount - v0, 0);
        rx_enable = 1'b1;
        wait_cyc(2);
        chk("R7 hold off when enabled", kb_clk_hold, 0);
    endtask

    task automatic t_mid_drop();
        int v0 = vcount;
        send_bit(1'b0);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        rx_enable = 1'b0;
        for (int i = 0; i < 6; i++) send_bit(1'b0);
        wait_cyc(TMO + 100);
        rx_enable = 1'b1;
        wait_cyc(5);
        chk("R10 no delivery", vcount - v0, 0);
        chk("R10 obf low", obf, 0);
        chk("R10 no timeout flag", timeout_err, 0);
        chk("R10 no parity flag", parity_err, 0);
    endtask

    task automatic t_timeout();
        int v0 = vcount;
        send_bit(1'b0);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        wait_cyc(TMO + 200);
        chk("R8 timeout flag", timeout_err, 1);
        chk("R8 obf low", obf, 0);
        chk("R8 no delivery", vcount - v0, 0);
        send_frame(8'h5A, 1'b1);
        chk("R8 partial discarded", rx_byte, 8'h5A);
        chk("R11 timeout cleared", timeout_err, 0);
        do_read();
    endtask

    task automatic t_false_start();
        int v0 = vcount;
        send_bit(1'b1);
        wait_cyc(TMO + 200);
        chk("R9 no timeout", timeout_err, 0);
        chk("R9 no delivery", vcount - v0, 0);
        chk("R9 obf low", obf, 0);
        send_frame(8'hC3, 1'b1);
        chk("R9 next frame", rx_byte, 8'hC3);
        chk("R9 parity ok", parity_err, 0);
        do_read();
    endtask

    initial begin
        wait_cyc(5);
        t_reset();
        rst_n = 1'b1;
        wait_cyc(3);
        t_basic();
        t_parity();
        t_irq();
        t_inhibit_full();
        t_disable();
        t_mid_drop();
        t_timeout();
        t_false_start();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule